// File: doc/BRIEF.md
# Triplicated Accumulator with Voted State Feedback

This block is a small sequential function, a wrapping accumulator, built three times over so that it tolerates upsets. Each of the three copies holds its own state register. Each copy also has its own majority voter, which reads all three registers. A copy's next state is computed from its voter's result and never from its own raw register. A corrupted register is therefore overwritten with the agreed value at the next clock edge. No single voter is shared by all copies.

A fourth voter forms the visible output. A per-copy flag shows which register currently differs from the voted value. Test inputs can XOR any bit pattern into any copy's register as it loads, which models an upset at a chosen cycle.

Top module: `tmr_accum`

## Requirements
- R1: While the active-low reset `rst_n` is low, every copy loads `RESET_VAL` (default 0). At the first edge after reset, `q` equals `RESET_VAL` and `mismatch` is zero.
- R2: At each rising edge with `en` high, the voted state becomes the previous voted state plus `din`, modulo 2^W. With `en` low, the voted state holds.
- R3: A flip pattern on only one copy's slice of `inj_flip` never changes `q` from the value given by R2. Slice k is bits [k*W +: W], for copies k = 0, 1 and 2.
- R4: Bit k of `mismatch` is high exactly when copy k's register differs from `q`. After an edge where only copy k received a nonzero flip, `mismatch` is one-hot on bit k.
- R5: A copy corrupted at one edge agrees with the others again after the next edge if no new flip arrives. `mismatch` then returns to zero.
- R6: Each output bit is the majority of that bit across the three copies, computed as (a&b)|(a&c)|(b&c). A bit flipped in two copies inverts that bit of `q`. Different bits flipped in two copies leave `q` correct.
- R7: Every copy computes its next state from the voted state. After a two-copy upset, all copies agree on the new voted value one edge later, and accumulation continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Accumulate enable |
| din | input | W | Addend |
| inj_flip | input | 3*W | Test upset masks, slice k XORed into copy k at load |
| q | output | W | Majority-voted state |
| mismatch | output | 3 | Bit k set when copy k differs from `q` |

## Verification
The bench drives a long random run of accumulate and hold cycles. Single-copy flips with one-bit and multi-bit masks land on random copies at random cycles. A faulty output there would show either a broken voter or a copy being fed from its own register. Directed cases then flip the same bit in two copies, which must corrupt `q`, and different bits in two copies, which must be masked. These cases separate a true per-bit vote from a whole-word vote. The cycle after each upset shows whether the state feedback resynchronises all copies.

// File: rtl/tmr_accum.sv
module tmr_accum #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [W-1:0]   din,
  input  logic [3*W-1:0] inj_flip,
  output logic [W-1:0]   q,
  output logic [2:0]     mismatch
);

  function automatic logic [W-1:0] vote(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  logic [W-1:0] st [3];
  logic [W-1:0] fb [3];
  logic [W-1:0] nx [3];

  for (genvar k = 0; k < 3; k++) begin : g_copy
    assign fb[k] = vote(st[0], st[1], st[2]);
    assign nx[k] = en ? fb[k] + din : fb[k];
    assign mismatch[k] = (st[k] != q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) st[k] <= RESET_VAL;
    end else begin
      for (int k = 0; k < 3; k++) st[k] <= nx[k] ^ inj_flip[k*W +: W];
    end
  end

  assign q = vote(st[0], st[1], st[2]);

  logic [2:0]   hit;
  logic [W-1:0] q_want;
  assign hit    = {|inj_flip[2*W +: W], |inj_flip[W +: W], |inj_flip[0 +: W]};
  assign q_want = en ? q + din : q;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (q == RESET_VAL && mismatch == 3'b000)); // R1
  AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit) <= 1) |=> (q == $past(q_want))); // R3
  AST_FLAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit) == 1) |=> (mismatch == $past(hit))); // R4
  AST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 3'b000) |=> (mismatch == 3'b000)); // R5

endmodule

// File: tb/tmr_accum_bench.sv
module tmr_accum_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [W-1:0]   din = '0;
  logic [3*W-1:0] inj_flip = '0;
  logic [W-1:0]   q;
  logic [2:0]     mismatch;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q;
  logic [2:0]   exp_mm;

  always #5 clk = ~clk;

  tmr_accum #(.W(W)) u_tmr_accum (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .inj_flip(inj_flip),
    .q(q), .mismatch(mismatch)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit e, input logic [W-1:0] d, input logic [W-1:0] m0,
                      input logic [W-1:0] m1, input logic [W-1:0] m2,
                      input string qtag, input string mtag);
    logic [W-1:0] base, mj;
    en = e; din = d; inj_flip = {m2, m1, m0};
    base = e ? W'(model + d) : model;
    mj = (m0 & m1) | (m0 & m2) | (m1 & m2);
    exp_q = base ^ mj;
    exp_mm = {m2 != mj, m1 != mj, m0 != mj};
    @(posedge clk);
    @(negedge clk);
    model = exp_q;
    chk(q == exp_q, qtag, q, exp_q);
    chk(mismatch == exp_mm, mtag, {5'b0, mismatch}, {5'b0, exp_mm});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(q == '0, "R1 reset q", q, '0);
    chk(mismatch == 3'b000, "R1 reset mismatch", {5'b0, mismatch}, '0);
    rst_n = 1'b1;
    model = '0;

    step(1'b1, 8'h05, '0, '0, '0, "R2 add", "R4 clean");
    step(1'b0, 8'h33, '0, '0, '0, "R2 hold", "R4 clean");
    step(1'b1, 8'hFE, '0, '0, '0, "R2 wrap", "R4 clean");

    for (int i = 0; i < 400; i++) begin
      bit doflip;
      int c;
      logic [W-1:0] m;
      logic [W-1:0] ms [3];
      doflip = ($urandom % 3) == 0;
      c = $urandom % 3;
      m = ($urandom % 2) ? W'(1 << ($urandom % W)) : W'($urandom);
      if (m == '0) m = 8'h01;
      ms[0] = '0; ms[1] = '0; ms[2] = '0;
      if (doflip) ms[c] = m;
      if (doflip)
        step($urandom % 2 == 1, W'($urandom), ms[0], ms[1], ms[2], "R3 single upset masked", "R4 flag copy");
      else
        step($urandom % 2 == 1, W'($urandom), '0, '0, '0, "R2 random", "R5 resync");
    end

    step(1'b1, 8'h10, '0, 8'h81, '0, "R3 directed", "R4 copy1");
    step(1'b1, 8'h01, '0, '0, '0, "R5 after upset", "R5 cleared");

    step(1'b0, 8'h00, 8'h04, '0, 8'h04, "R6 same bit two copies", "R6 flags");
    step(1'b1, 8'h02, '0, '0, '0, "R7 continue from voted", "R7 all agree");
    step(1'b1, 8'h00, 8'h01, 8'h02, '0, "R6 diff bits masked", "R6 flags diff");
    step(1'b0, 8'h00, '0, '0, '0, "R7 hold", "R7 clean");

    rst_n = 1'b0;
    @(negedge clk);
    chk(q == '0, "R1 re-reset q", q, '0);
    chk(mismatch == 3'b000, "R1 re-reset mismatch", {5'b0, mismatch}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule